// File: doc/BRIEF.md
# Victim Block Drain Buffer

This block sits between a write-back data cache and the next memory level. When the cache evicts a modified line, it hands the whole 64-byte line and its block address to this buffer. The buffer keeps up to eight such lines and writes them out in the background while the cache goes on serving hits and misses. A line leaves as a burst of eight 8-byte beats on a valid/ready write channel.

Once all eight slots are taken, the buffer raises a full flag and the cache holds off its next dirty eviction. Lines that were never modified are refused, because memory already has their contents.

The cache resolves a miss by probing the buffer with the miss address. If that block is still waiting to be written, the buffer returns the held copy, so the cache never reads a stale line back from memory.

Top module: `evict_drain_buf`

## Requirements
- R1: After a synchronous active-low reset, `buf_full`, `mem_valid` and `probe_hit` are 0.
- R2: A block offered with `evict_dirty` = 0 is not stored. It never shows up on the memory channel and never hits a probe.
- R3: Each stored block goes out as eight beats. Beat k carries bits [64k+63:64k] of the block. `mem_first` is 1 only on beat 0 and `mem_last` is 1 only on beat 7. `mem_addr` holds the block address for the whole burst.
- R4: Blocks are written out in the order they were accepted, oldest first.
- R5: While `mem_valid` = 1 and `mem_ready` = 0, the next cycle still shows `mem_valid` = 1 with unchanged `mem_data`, `mem_addr` and `mem_first`.
- R6: With eight blocks held and no burst finishing, `buf_full` = 1. An offer made while `buf_full` = 1 is dropped, and it never shows up on the memory channel or on a probe.
- R7: A slot is released only when the final beat of its burst is accepted. `buf_full` stays 1 while beats 0 to 6 of the oldest block are accepted.
- R8: When the final beat is accepted in the same cycle as an insert, occupancy is unchanged. `buf_full` is 0 during that cycle, so the insert is taken, and it reads 1 again in the next cycle.
- R9: `probe_hit` is 1 only while a held block has an address equal to `probe_addr`, and `probe_data` then carries that block. Once the block has drained, the probe misses.
- R10: If several held blocks match the probe, `probe_data` returns the one inserted most recently.
- R11: A block inserted while another block's burst is in flight is stored without disturbing the burst, and it is written after that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evict_valid | input | 1 | Cache offers an evicted block this cycle |
| evict_dirty | input | 1 | The offered block was modified |
| evict_addr | input | ADDR_W | Block address of the offered block |
| evict_data | input | BLK_BYTES*8 | Offered block contents, byte 0 in the low bits |
| buf_full | output | 1 | No slot is free; the cache must wait |
| probe_addr | input | ADDR_W | Miss address to look up |
| probe_hit | output | 1 | A held block matches `probe_addr` |
| probe_data | output | BLK_BYTES*8 | Newest matching held block |
| mem_valid | output | 1 | A write beat is presented |
| mem_ready | input | 1 | Next level accepts the beat |
| mem_first | output | 1 | Beat 0 of a burst |
| mem_last | output | 1 | Final beat of a burst |
| mem_addr | output | ADDR_W | Block address of the burst |
| mem_data | output | BEAT_BYTES*8 | Beat payload |

## Verification
The drain path runs in three modes:
- An always-ready sink confirms the beat layout and the flag positions.
- A sink that drops ready one cycle in three separates correct stall holding from beats that advance or change under back-pressure.
- A sink held at not-ready fills all eight slots, then releases beats one at a time. This pins down the exact cycle in which a slot is freed. It also lines up an insert with the final beat, which exposes off-by-one errors in the occupancy count and the full flag.

Two further patterns cover the probe and concurrency. Offering clean and overflow blocks, and inserting the same address twice, checks that refused blocks stay invisible and that the probe returns the newest copy. Inserting during a live burst shows that storage and draining do not interfere.

// File: rtl/evb_pkg.sv
// Shared defaults and helpers for the victim block drain buffer.
package evb_pkg;
    localparam int unsigned EVB_DEPTH      = 8;
    localparam int unsigned EVB_ADDR_W     = 32;
    localparam int unsigned EVB_BLK_BYTES  = 64;
    localparam int unsigned EVB_BEAT_BYTES = 8;

    // Modular add used for circular slot indices.
    function automatic int unsigned wrap_add(int unsigned p, int unsigned k, int unsigned n);
        return (p + k) % n;
    endfunction
endpackage

// File: rtl/evb_ctrl.sv
// Slot bookkeeping: write/read pointers, occupancy, full/empty and the
// per-slot valid mask. Assumes DEPTH >= 2; a pop is only requested when
// the buffer is non-empty (the drain engine sees empty).
module evb_ctrl #(
    parameter int unsigned DEPTH = evb_pkg::EVB_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_req,
    input  logic             pop,
    output logic             push,
    output logic             full,
    output logic             empty,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [DEPTH-1:0] ent_valid
);
    logic [CNT_W-1:0] count;

    // Full drops in the cycle the head block completes, so a swap is allowed.
    assign full  = (count == CNT_W'(DEPTH)) && !pop;
    assign empty = (count == '0);
    assign push  = ins_req && !full;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= PTR_W'(evb_pkg::wrap_add(wr_ptr, 1, DEPTH));
            if (pop)  rd_ptr <= PTR_W'(evb_pkg::wrap_add(rd_ptr, 1, DEPTH));
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // A slot is valid when its age offset from the head is below occupancy.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int unsigned off;
            off = evb_pkg::wrap_add(i, DEPTH - rd_ptr, DEPTH);
            ent_valid[i] = (off < count);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !pop) |=> count == CNT_W'(DEPTH)); // R6
    AST_SWAP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count)); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0); // R7
endmodule

// File: rtl/evb_store.sv
// Block storage with an associative probe. Each slot holds a full block
// and its address. The probe scans from oldest to newest so that the
// newest match wins. Assumes the caller never writes a live slot.
module evb_store #(
    parameter int unsigned DEPTH  = evb_pkg::EVB_DEPTH,
    parameter int unsigned ADDR_W = evb_pkg::EVB_ADDR_W,
    parameter int unsigned BLK_W  = evb_pkg::EVB_BLK_BYTES * 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [DEPTH-1:0]  ent_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BLK_W-1:0]  wr_data,
    output logic [ADDR_W-1:0] head_addr,
    output logic [BLK_W-1:0]  head_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic [BLK_W-1:0]  probe_data
);
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [BLK_W-1:0]  slot_data [DEPTH];
    logic [PTR_W-1:0]  hit_sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture an accepted block into its slot.
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) begin
                slot_addr[g] <= wr_addr;
                slot_data[g] <= wr_data;
            end
        end
    end

    assign head_addr = slot_addr[rd_ptr];
    assign head_data = slot_data[rd_ptr];

    // Oldest-to-newest scan; a later match overrides an earlier one.
    always_comb begin
        probe_hit = 1'b0;
        hit_sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int unsigned idx;
            idx = evb_pkg::wrap_add(rd_ptr, k, DEPTH);
            if (ent_valid[idx] && slot_addr[idx] == probe_addr) begin
                probe_hit = 1'b1;
                hit_sel   = PTR_W'(idx);
            end
        end
    end

    assign probe_data = slot_data[hit_sel];

    AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!ent_valid[wr_ptr] || (pop && wr_ptr == rd_ptr))); // R6
endmodule

// File: rtl/evb_drain.sv
// Burst engine: serialises the head block into fixed-size beats on a
// valid/ready channel and flags completion on the accepted final beat.
// Assumes the head block stays put until completion is flagged.
module evb_drain #(
    parameter int unsigned ADDR_W = evb_pkg::EVB_ADDR_W,
    parameter int unsigned BLK_W  = evb_pkg::EVB_BLK_BYTES * 8,
    parameter int unsigned BEAT_W = evb_pkg::EVB_BEAT_BYTES * 8,
    localparam int unsigned BEATS = BLK_W / BEAT_W,
    localparam int unsigned BC_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              have_ent,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [BLK_W-1:0]  head_data,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic              mem_first,
    output logic              mem_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_data,
    output logic              done
);
    logic [BC_W-1:0]   beat;
    logic [BEAT_W-1:0] slice [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_slice
        assign slice[b] = head_data[b*BEAT_W +: BEAT_W];
    end

    assign mem_valid = have_ent;
    assign mem_first = (beat == '0);
    assign mem_last  = (beat == BC_W'(BEATS - 1));
    assign mem_addr  = head_addr;
    assign mem_data  = slice[beat];
    assign done      = mem_valid && mem_ready && mem_last;

    // Advance the beat index on each accepted beat, wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) beat <= '0;
        else if (mem_valid && mem_ready) beat <= mem_last ? '0 : beat + 1'b1;
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data)
            && $stable(mem_addr) && $stable(mem_first))); // R5
    AST_FIRST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!mem_valid || mem_first)); // R3
    AST_ADDR_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_last) |=> $stable(mem_addr)); // R3
endmodule

// File: rtl/evict_drain_buf.sv
// Top level of the victim block drain buffer. Accepts dirty evicted blocks,
// stores up to DEPTH of them, drains them oldest-first as beats and answers
// address probes. Assumes BLK_BYTES is a multiple of BEAT_BYTES.
module evict_drain_buf #(
    parameter int unsigned DEPTH      = evb_pkg::EVB_DEPTH,
    parameter int unsigned ADDR_W     = evb_pkg::EVB_ADDR_W,
    parameter int unsigned BLK_BYTES  = evb_pkg::EVB_BLK_BYTES,
    parameter int unsigned BEAT_BYTES = evb_pkg::EVB_BEAT_BYTES,
    localparam int unsigned BLK_W  = BLK_BYTES * 8,
    localparam int unsigned BEAT_W = BEAT_BYTES * 8,
    localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic              evict_dirty,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [BLK_W-1:0]  evict_data,
    output logic              buf_full,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic [BLK_W-1:0]  probe_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_first,
    output logic              mem_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_data
);
    logic             ins_req, push, pop, empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [DEPTH-1:0] ent_valid;
    logic [ADDR_W-1:0] head_addr;
    logic [BLK_W-1:0]  head_data;

    // Only modified blocks need writing back.
    assign ins_req = evict_valid && evict_dirty;

    evb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ins_req(ins_req), .pop(pop),
        .push(push), .full(buf_full), .empty(empty),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ent_valid(ent_valid)
    );

    evb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ent_valid(ent_valid),
        .wr_addr(evict_addr), .wr_data(evict_data),
        .head_addr(head_addr), .head_data(head_data),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_data(probe_data)
    );

    evb_drain #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BEAT_W(BEAT_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .have_ent(!empty),
        .head_addr(head_addr), .head_data(head_data), .mem_ready(mem_ready),
        .mem_valid(mem_valid), .mem_first(mem_first), .mem_last(mem_last),
        .mem_addr(mem_addr), .mem_data(mem_data), .done(pop)
    );

    AST_CLEAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !evict_dirty && !pop) |=> $stable(ent_valid)); // R2
endmodule

// File: tb/evict_drain_buf_tb.sv
`timescale 1ns/100ps
module evict_drain_buf_tb;
    localparam int AW = 32;
    localparam int BW = 512;
    localparam int WW = 64;
    localparam int NB = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n, evict_valid, evict_dirty, buf_full, probe_hit;
    logic mem_valid, mem_ready, mem_first, mem_last;
    logic [AW-1:0] evict_addr, probe_addr, mem_addr;
    logic [BW-1:0] evict_data, probe_data;
    logic [WW-1:0] mem_data;

    evict_drain_buf u_dut (
        .clk(clk), .rst_n(rst_n), .evict_valid(evict_valid), .evict_dirty(evict_dirty),
        .evict_addr(evict_addr), .evict_data(evict_data), .buf_full(buf_full),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_data(probe_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_first(mem_first),
        .mem_last(mem_last), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit stall_en = 0;

    logic [AW-1:0] rx_addr [64];
    logic [BW-1:0] rx_data [64];
    int rx_n = 0;

    task automatic chk(bit ok, string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] mkblk(int s);
        logic [BW-1:0] b;
        for (int w = 0; w < BW/32; w++) b[32*w +: 32] = {s[15:0] ^ 16'hC3A0, w[15:0]};
        return b;
    endfunction

    function automatic logic [AW-1:0] mkaddr(int s);
        return 32'h4000_0000 + AW'(s * 64);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Ready pattern generator: drops ready one cycle in three.
    always @(negedge clk) if (stall_en) mem_ready = (cyc % 3) != 1;

    // Watchdog.
    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Beat monitor: samples just before each rising edge.
    int bc = 0;
    logic [AW-1:0] cur_addr;
    logic [BW-1:0] cur_blk;
    bit pend = 0;
    logic [AW-1:0] p_addr;
    logic [WW-1:0] p_data;
    always begin
        @(negedge clk); #1.5;
        if (rst_n) begin
            if (pend)
                chk(mem_valid && mem_data == p_data && mem_addr == p_addr, "R5", "held beat",
                    {mem_valid, mem_data}, {1'b1, p_data});
            if (mem_valid && mem_ready) begin
                chk(mem_first == (bc == 0) && mem_last == (bc == NB-1), "R3", "beat flags",
                    {mem_first, mem_last}, {bc == 0, bc == NB-1});
                if (bc == 0) cur_addr = mem_addr;
                else chk(mem_addr == cur_addr, "R3", "burst addr", mem_addr, cur_addr);
                cur_blk[bc*WW +: WW] = mem_data;
                if (bc == NB-1) begin
                    rx_addr[rx_n] = cur_addr;
                    rx_data[rx_n] = cur_blk;
                    rx_n++;
                    bc = 0;
                end else bc++;
            end
            pend = mem_valid && !mem_ready;
            p_addr = mem_addr;
            p_data = mem_data;
        end
    end

    task automatic put(logic [AW-1:0] a, logic [BW-1:0] d, bit dirty);
        @(negedge clk);
        evict_valid = 1'b1; evict_dirty = dirty; evict_addr = a; evict_data = d;
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); #1.5; n++; end while ((mem_valid || evict_valid) && n < 2000);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_probe(logic [AW-1:0] a, bit exp_hit, logic [BW-1:0] exp_d, string req);
        @(negedge clk); probe_addr = a; #1.5;
        chk(probe_hit == exp_hit, req, "probe hit", probe_hit, exp_hit);
        if (exp_hit) chk(probe_data == exp_d, req, "probe data", probe_data, exp_d);
    endtask

    task automatic expect_rx(int idx, logic [AW-1:0] a, logic [BW-1:0] d, string req);
        chk(rx_n > idx && rx_addr[idx] == a, req, "drained addr", rx_addr[idx], a);
        chk(rx_data[idx] == d, req, "drained data", rx_data[idx], d);
    endtask

    task automatic t_reset();
        @(negedge clk); #1.5;
        chk(!buf_full && !mem_valid && !probe_hit, "R1", "reset outputs",
            {buf_full, mem_valid, probe_hit}, 3'b000);
    endtask

    task automatic t_clean();
        int n0 = rx_n;
        mem_ready = 1'b1;
        put(mkaddr(90), mkblk(90), 1'b0);
        do_probe(mkaddr(90), 1'b0, '0, "R2");
        repeat (20) @(negedge clk);
        #1.5;
        chk(!mem_valid && rx_n == n0, "R2", "clean block drained", rx_n, n0);
    endtask

    task automatic t_single();
        int n0 = rx_n;
        mem_ready = 1'b1;
        put(mkaddr(1), mkblk(1), 1'b1);
        wait_idle();
        expect_rx(n0, mkaddr(1), mkblk(1), "R3");
        chk(rx_n == n0 + 1, "R3", "block count", rx_n, n0 + 1);
    endtask

    task automatic t_order_stall();
        int n0 = rx_n;
        stall_en = 1;
        for (int i = 0; i < 3; i++) put(mkaddr(10 + i), mkblk(10 + i), 1'b1);
        wait_idle();
        stall_en = 0;
        @(negedge clk); mem_ready = 1'b1;
        for (int i = 0; i < 3; i++) expect_rx(n0 + i, mkaddr(10 + i), mkblk(10 + i), "R4");
    endtask

    task automatic t_full_swap();
        int n0 = rx_n;
        @(negedge clk); mem_ready = 1'b0;
        for (int i = 0; i < 8; i++) put(mkaddr(20 + i), mkblk(20 + i), 1'b1);
        #1.5;
        chk(buf_full, "R6", "full after eight", buf_full, 1'b1);
        // Offer while full: must be dropped.
        @(negedge clk);
        evict_valid = 1'b1; evict_dirty = 1'b1; evict_addr = mkaddr(77); evict_data = mkblk(77);
        repeat (3) @(negedge clk);
        evict_valid = 1'b0;
        do_probe(mkaddr(77), 1'b0, '0, "R6");
        do_probe(mkaddr(23), 1'b1, mkblk(23), "R9");
        // Release beats one by one; line up an insert with the last beat.
        for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            mem_ready = 1'b1;
            if (k == NB-1) begin
                evict_valid = 1'b1; evict_dirty = 1'b1;
                evict_addr = mkaddr(40); evict_data = mkblk(40);
            end
            #1.5;
            if (k < NB-1) chk(buf_full, "R7", "full during burst", buf_full, 1'b1);
            else chk(!buf_full && mem_last, "R8", "full on final beat",
                     {buf_full, mem_last}, 2'b01);
        end
        @(negedge clk);
        evict_valid = 1'b0; mem_ready = 1'b0;
        #1.5;
        chk(buf_full, "R8", "occupancy after swap", buf_full, 1'b1);
        @(negedge clk); mem_ready = 1'b1;
        wait_idle();
        chk(rx_n == n0 + 9, "R6", "blocks drained", rx_n, n0 + 9);
        for (int i = 0; i < 8; i++) expect_rx(n0 + i, mkaddr(20 + i), mkblk(20 + i), "R4");
        expect_rx(n0 + 8, mkaddr(40), mkblk(40), "R8");
        do_probe(mkaddr(23), 1'b0, '0, "R9");
    endtask

    task automatic t_dup();
        int n0 = rx_n;
        @(negedge clk); mem_ready = 1'b0;
        put(mkaddr(50), mkblk(51), 1'b1);
        put(mkaddr(50), mkblk(52), 1'b1);
        do_probe(mkaddr(50), 1'b1, mkblk(52), "R10");
        @(negedge clk); mem_ready = 1'b1;
        wait_idle();
        expect_rx(n0, mkaddr(50), mkblk(51), "R10");
        expect_rx(n0 + 1, mkaddr(50), mkblk(52), "R10");
    endtask

    task automatic t_concurrent();
        int n0 = rx_n;
        @(negedge clk); mem_ready = 1'b1;
        put(mkaddr(60), mkblk(60), 1'b1);
        repeat (2) @(negedge clk);
        #1.5;
        chk(mem_valid && !mem_first, "R11", "burst in flight", {mem_valid, mem_first}, 2'b10);
        put(mkaddr(61), mkblk(61), 1'b1);
        wait_idle();
        expect_rx(n0, mkaddr(60), mkblk(60), "R11");
        expect_rx(n0 + 1, mkaddr(61), mkblk(61), "R11");
    endtask

    initial begin
        rst_n = 1'b0; evict_valid = 1'b0; evict_dirty = 1'b0;
        evict_addr = '0; evict_data = '0; probe_addr = '0; mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_clean();
        t_single();
        t_order_stall();
        t_full_swap();
        t_dup();
        t_concurrent();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule